// File: doc/BRIEF.md
# Small-Loop Detector and Micro-op Replayer

This block sits beside a micro-op decode queue and watches each decoded micro-op as it is written. A micro-op flagged as the landing point of a taken backward branch opens a candidate loop body. The following micro-ops are captured until the next landing point closes the body. While the body is captured, four limits are tracked: the micro-op count, the number of distinct 16-byte fetch lines, the number of taken branches, and whether any taken branch was a return. Any limit that is crossed drops the candidate.

A body that qualifies is then checked on later passes. Each pass whose length matches the captured body counts as one more iteration. When the number of observed passes exceeds a minimum (parameter, default 64), the block locks the captured body. It raises a gate that stalls fetch and decode, and it streams the captured micro-ops back, one per cycle, wrapping around. A flush or mispredict drops all of this at once. The micro-op payload is opaque to the block.

Top module: `loop_replay`

## Requirements
- R1: After reset, `replay_o`, `gate_o` and `rp_valid_o` are low.
- R2: An accepted micro-op with `in_tgt_i` high opens a candidate body, and that micro-op is body entry 0. The next accepted micro-op with `in_tgt_i` high closes the body. The body length is the number of micro-ops from the opening micro-op up to, but not including, the closing one.
- R3: A body of up to MAX_UOPS (28) micro-ops can qualify. Appending micro-op number MAX_UOPS+1 drops the candidate, and no replay follows.
- R4: Fetch lines are counted as follows. Entry 0 counts as one line, and each later micro-op whose `in_line_i` differs from the previous micro-op's adds one. A body of up to MAX_LINES (4) lines can qualify; one more line drops the candidate.
- R5: Micro-ops with `in_taken_i` high are counted, and the closing branch is included. Up to MAX_TAKEN (4) can qualify; a fifth drops the candidate.
- R6: A micro-op with both `in_taken_i` and `in_ret_i` high drops the candidate, both during capture and during iteration counting.
- R7: Passes are counted from the capture pass on, and each close of a matching-length pass adds one. Replay starts in the cycle after the close that brings the count above MIN_ITER (64). With exactly MIN_ITER passes counted, replay stays off.
- R8: During replay, `rp_valid_o` is high and `rp_uop_o` shows one captured entry per cycle in captured order. The stream starts at entry 1, because entry 0 was just delivered by decode; for a one-entry body it starts at entry 0. After the last entry it wraps to entry 0.
- R9: While replay is active, `gate_o` is high and writes on `in_valid_i` are ignored, whatever their flags. The replayed stream is unchanged by them.
- R10: `flush_i` ends replay, so `replay_o`, `gate_o` and `rp_valid_o` are low in the next cycle. It also discards the captured body and the pass count, so a new loop must go through full qualification again.
- R11: While passes are being counted, a pass that runs longer than the body, or closes after fewer micro-ops, discards the candidate. Capture then begins again at the next landing point.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_i | input | 1 | Flush or mispredict; drops replay and all loop state |
| in_valid_i | input | 1 | A decoded micro-op is written this cycle |
| in_uop_i | input | PW | Opaque micro-op payload |
| in_line_i | input | LINE_W | Index of the 16-byte fetch line the micro-op came from |
| in_taken_i | input | 1 | Micro-op is a taken branch |
| in_ret_i | input | 1 | Micro-op is a return |
| in_tgt_i | input | 1 | Micro-op is the landing point of a taken backward branch |
| replay_o | output | 1 | Replay is active |
| gate_o | output | 1 | Stall fetch and decode |
| rp_valid_o | output | 1 | `rp_uop_o` carries a replayed micro-op |
| rp_uop_o | output | PW | Replayed micro-op payload |

## Verification
Loops are driven with unique payloads and shaped to sit just inside or just past each limit: 28 against 29 micro-ops, 4 against 5 fetch lines, 4 against 5 taken branches, and a return as the closing branch. Each of these shows whether one particular counter, and only that counter, makes the decision. Running the same loop for 64 and then for 65 counted passes separates a correct threshold from an off-by-one. The replayed payload order, checked through a scoreboard over more than two wraps and with a one-entry loop, exposes errors in the start entry and the wrap point. Garbage writes during replay, a flush followed by one fresh pass, and a switch from a three-entry to a four-entry loop check that stale state is neither used nor kept.

// File: rtl/loop_replay_pkg.sv
package loop_replay_pkg;

  typedef enum logic [1:0] {
    LR_IDLE    = 2'd0,
    LR_CAPTURE = 2'd1,
    LR_VERIFY  = 2'd2,
    LR_REPLAY  = 2'd3
  } lr_state_e;

  // Next replay index, wrapping to zero after the last body entry.
  function automatic int unsigned wrap_next(int unsigned idx, int unsigned len);
    return (idx + 1 >= len) ? 0 : idx + 1;
  endfunction

  // True when a candidate body has crossed any qualification limit.
  function automatic logic over_limit(int unsigned cnt, int unsigned lines,
                                      int unsigned taken, logic ret_seen,
                                      int unsigned max_u, int unsigned max_l,
                                      int unsigned max_t);
    return (cnt > max_u) || (lines > max_l) || (taken > max_t) || ret_seen;
  endfunction

endpackage

// File: rtl/lr_qualify.sv
module lr_qualify
  import loop_replay_pkg::*;
#(
  parameter int MAX_UOPS  = 28,
  parameter int MAX_LINES = 4,
  parameter int MAX_TAKEN = 4,
  parameter int LINE_W    = 8,
  localparam int CW = $clog2(MAX_UOPS + 2)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_i,
  input  logic              start_i,
  input  logic              add_i,
  input  logic [LINE_W-1:0] line_i,
  input  logic              taken_i,
  input  logic              ret_i,
  output logic [CW-1:0]     cnt_o,
  output logic              violate_o
);
  localparam int LW = $clog2(MAX_LINES + 2);
  localparam int TW = $clog2(MAX_TAKEN + 2);

  logic [CW-1:0]     cnt_q, cnt_n;
  logic [LW-1:0]     lines_q, lines_n;
  logic [TW-1:0]     taken_q, taken_n;
  logic              ret_q, ret_n;
  logic [LINE_W-1:0] last_q;

  always_comb begin
    cnt_n   = (start_i ? '0 : cnt_q) + CW'(1);
    lines_n = (start_i ? '0 : lines_q) + LW'(start_i || (line_i != last_q));
    taken_n = (start_i ? '0 : taken_q) + TW'(taken_i);
    ret_n   = (start_i ? 1'b0 : ret_q) | (taken_i & ret_i);
    violate_o = (start_i || add_i) &&
                over_limit(32'(cnt_n), 32'(lines_n), 32'(taken_n), ret_n,
                           MAX_UOPS, MAX_LINES, MAX_TAKEN);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear_i || violate_o) begin
      cnt_q   <= '0;
      lines_q <= '0;
      taken_q <= '0;
      ret_q   <= 1'b0;
      last_q  <= '0;
    end else if (start_i || add_i) begin
      cnt_q   <= cnt_n;
      lines_q <= lines_n;
      taken_q <= taken_n;
      ret_q   <= ret_n;
      last_q  <= line_i;
    end
  end

  assign cnt_o = cnt_q;

endmodule

// File: rtl/lr_body.sv
module lr_body #(
  parameter int DEPTH = 28,
  parameter int PW    = 16,
  localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          wr_en_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [PW-1:0] wr_data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [PW-1:0] rd_data_o
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i && (32'(wr_idx_i) < DEPTH)) mem[wr_idx_i] <= wr_data_i;
  end

  assign rd_data_o = (32'(rd_idx_i) < DEPTH) ? mem[rd_idx_i] : '0;

endmodule

// File: rtl/loop_replay.sv
module loop_replay
  import loop_replay_pkg::*;
#(
  parameter int PW        = 16,
  parameter int LINE_W    = 8,
  parameter int MAX_UOPS  = 28,
  parameter int MAX_LINES = 4,
  parameter int MAX_TAKEN = 4,
  parameter int MIN_ITER  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush_i,
  input  logic              in_valid_i,
  input  logic [PW-1:0]     in_uop_i,
  input  logic [LINE_W-1:0] in_line_i,
  input  logic              in_taken_i,
  input  logic              in_ret_i,
  input  logic              in_tgt_i,
  output logic              replay_o,
  output logic              gate_o,
  output logic              rp_valid_o,
  output logic [PW-1:0]     rp_uop_o
);
  localparam int CW  = $clog2(MAX_UOPS + 2);
  localparam int IW  = (MAX_UOPS > 1) ? $clog2(MAX_UOPS) : 1;
  localparam int ITW = $clog2(MIN_ITER + 2);
  localparam logic [ITW-1:0] ITER_LIM = ITW'(MIN_ITER);
  localparam logic [CW-1:0]  UOP_LIM  = CW'(MAX_UOPS);

  lr_state_e      state_q, state_d;
  logic [CW-1:0]  len_q, len_d, pos_q, pos_d;
  logic [ITW-1:0] iter_q, iter_d, iter_inc;
  logic [IW-1:0]  rd_q, rd_d;

  // named internal events, used by the bound checker
  logic fire, ret_hit, in_capture;
  logic ev_abort, ev_close, ev_pass, ev_enter;

  logic          q_clear, q_start, q_add, q_violate;
  logic [CW-1:0] q_cnt;
  logic          wr_en;
  logic [IW-1:0] wr_idx, rd_idx;
  logic [PW-1:0] rd_data;

  lr_qualify #(
    .MAX_UOPS (MAX_UOPS),
    .MAX_LINES(MAX_LINES),
    .MAX_TAKEN(MAX_TAKEN),
    .LINE_W   (LINE_W)
  ) u_qual (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear_i  (q_clear),
    .start_i  (q_start),
    .add_i    (q_add),
    .line_i   (in_line_i),
    .taken_i  (in_taken_i),
    .ret_i    (in_ret_i),
    .cnt_o    (q_cnt),
    .violate_o(q_violate)
  );

  lr_body #(
    .DEPTH(MAX_UOPS),
    .PW   (PW)
  ) u_body (
    .clk      (clk),
    .wr_en_i  (wr_en),
    .wr_idx_i (wr_idx),
    .wr_data_i(in_uop_i),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data)
  );

  assign fire       = in_valid_i && (state_q != LR_REPLAY);
  assign ret_hit    = in_taken_i && in_ret_i;
  assign in_capture = (state_q == LR_CAPTURE);
  assign iter_inc   = iter_q + ITW'(1);
  assign rd_idx     = rd_q;

  always_comb begin
    state_d  = state_q;
    len_d    = len_q;
    pos_d    = pos_q;
    iter_d   = iter_q;
    rd_d     = rd_q;
    q_clear  = 1'b0;
    q_start  = 1'b0;
    q_add    = 1'b0;
    wr_en    = 1'b0;
    wr_idx   = '0;
    ev_abort = 1'b0;
    ev_close = 1'b0;
    ev_pass  = 1'b0;
    ev_enter = 1'b0;

    unique case (state_q)
      LR_IDLE: begin
        if (fire && in_tgt_i) begin
          q_start = 1'b1;
          wr_en   = 1'b1;
          if (q_violate) ev_abort = 1'b1;
          else           state_d  = LR_CAPTURE;
        end
      end
      LR_CAPTURE: begin
        if (fire && in_tgt_i) begin
          ev_close = 1'b1;
          len_d    = q_cnt;
          pos_d    = CW'(1);
          iter_d   = ITW'(1);
          if (MIN_ITER == 0) begin
            ev_enter = 1'b1;
            state_d  = LR_REPLAY;
            rd_d     = IW'(wrap_next(0, 32'(q_cnt)));
          end else begin
            state_d  = LR_VERIFY;
          end
        end else if (fire) begin
          q_add  = 1'b1;
          wr_en  = (q_cnt < UOP_LIM);
          wr_idx = IW'(q_cnt);
          if (q_violate) ev_abort = 1'b1;
        end
      end
      LR_VERIFY: begin
        if (fire && ret_hit) begin
          ev_abort = 1'b1;
        end else if (fire && in_tgt_i) begin
          if (pos_q == len_q) begin
            ev_pass = 1'b1;
            pos_d   = CW'(1);
            if (iter_inc > ITER_LIM) begin
              ev_enter = 1'b1;
              state_d  = LR_REPLAY;
              rd_d     = IW'(wrap_next(0, 32'(len_q)));
            end else begin
              iter_d   = iter_inc;
            end
          end else begin
            // short pass: restart capture at this landing point
            q_start = 1'b1;
            wr_en   = 1'b1;
            iter_d  = '0;
            if (q_violate) ev_abort = 1'b1;
            else           state_d  = LR_CAPTURE;
          end
        end else if (fire) begin
          if (pos_q >= len_q) ev_abort = 1'b1;
          else                pos_d    = pos_q + CW'(1);
        end
      end
      LR_REPLAY: begin
        rd_d = IW'(wrap_next(32'(rd_q), 32'(len_q)));
      end
      default: state_d = LR_IDLE;
    endcase

    if (ev_abort || flush_i) begin
      state_d = LR_IDLE;
      len_d   = '0;
      pos_d   = '0;
      iter_d  = '0;
      rd_d    = '0;
      q_clear = 1'b1;
    end
    if (flush_i) begin
      q_start = 1'b0;
      q_add   = 1'b0;
      wr_en   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= LR_IDLE;
      len_q   <= '0;
      pos_q   <= '0;
      iter_q  <= '0;
      rd_q    <= '0;
    end else begin
      state_q <= state_d;
      len_q   <= len_d;
      pos_q   <= pos_d;
      iter_q  <= iter_d;
      rd_q    <= rd_d;
    end
  end

  assign replay_o   = (state_q == LR_REPLAY);
  assign gate_o     = (state_q == LR_REPLAY);
  assign rp_valid_o = (state_q == LR_REPLAY);
  assign rp_uop_o   = rp_valid_o ? rd_data : '0;

endmodule

// File: rtl/loop_replay_chk.sv
module loop_replay_chk #(
  parameter int MAX_UOPS = 28,
  parameter int MIN_ITER = 64,
  localparam int CW  = $clog2(MAX_UOPS + 2),
  localparam int IW  = (MAX_UOPS > 1) ? $clog2(MAX_UOPS) : 1,
  localparam int ITW = $clog2(MIN_ITER + 2)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           flush_i,
  input logic           in_valid_i,
  input logic           in_tgt_i,
  input logic           replay_o,
  input logic           gate_o,
  input logic           ev_abort,
  input logic           in_capture,
  input logic [CW-1:0]  q_cnt,
  input logic [ITW-1:0] iter_q,
  input logic [IW-1:0]  rd_q,
  input logic [CW-1:0]  len_q
);
  // R10
  flush_drops_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (!replay_o && !gate_o));

  // R7
  entry_threshold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replay_o) |-> ($past(iter_q) == ITW'(MIN_ITER)));

  // R2
  entry_on_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(replay_o) |-> $past(in_valid_i && in_tgt_i));

  // R8
  replay_index_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay_o |-> (CW'(rd_q) < len_q));

  // R3
  capture_count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_capture |-> (q_cnt <= CW'(MAX_UOPS)));

  // R6
  abort_blocks_replay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_abort |=> !replay_o);

endmodule

bind loop_replay loop_replay_chk #(
  .MAX_UOPS(MAX_UOPS),
  .MIN_ITER(MIN_ITER)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .flush_i   (flush_i),
  .in_valid_i(in_valid_i),
  .in_tgt_i  (in_tgt_i),
  .replay_o  (replay_o),
  .gate_o    (gate_o),
  .ev_abort  (ev_abort),
  .in_capture(in_capture),
  .q_cnt     (q_cnt),
  .iter_q    (iter_q),
  .rd_q      (rd_q),
  .len_q     (len_q)
);

// File: tb/loop_replay_test.sv
module loop_replay_test;
  localparam int CLK_PERIOD = 10;
  localparam int PW     = 16;
  localparam int LINE_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic flush = 1'b0;
  logic in_valid = 1'b0;
  logic [PW-1:0] in_uop = '0;
  logic [LINE_W-1:0] in_line = '0;
  logic in_taken = 1'b0;
  logic in_ret = 1'b0;
  logic in_tgt = 1'b0;
  logic replay, gate, rp_valid;
  logic [PW-1:0] rp_uop;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [PW-1:0] exp_q[$];
  logic [PW-1:0] mon_e;

  always #(CLK_PERIOD/2) clk = ~clk;

  loop_replay uut (
    .clk(clk), .rst_n(rst_n), .flush_i(flush),
    .in_valid_i(in_valid), .in_uop_i(in_uop), .in_line_i(in_line),
    .in_taken_i(in_taken), .in_ret_i(in_ret), .in_tgt_i(in_tgt),
    .replay_o(replay), .gate_o(gate), .rp_valid_o(rp_valid), .rp_uop_o(rp_uop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as replayed micro-ops appear (R8, R9)
  always @(negedge clk) begin
    if (rst_n && rp_valid && exp_q.size() > 0) begin
      mon_e = exp_q.pop_front();
      check(rp_uop == mon_e, "R8 replay order", int'(rp_uop), int'(mon_e));
      check(gate == 1'b1, "R9 gate high during replay", int'(gate), 1);
    end
  end

  task automatic drive_one(input int n, input int ldiv, input int ntk,
                           input bit ret, input int base, input int i);
    @(negedge clk);
    in_valid = 1'b1;
    in_uop   = PW'(base + i);
    in_line  = LINE_W'(i / ldiv);
    in_taken = (i == n - 1) || (i < ntk - 1);
    in_ret   = ret && (i == n - 1);
    in_tgt   = (i == 0);
  endtask

  task automatic drive_pass(input int n, input int ldiv, input int ntk,
                            input bit ret, input int base);
    for (int i = 0; i < n; i++) drive_one(n, ldiv, ntk, ret, base, i);
  endtask

  task automatic quiet();
    in_valid = 1'b0; in_tgt = 1'b0; in_taken = 1'b0; in_ret = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk); quiet(); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  // passes full passes, then the landing micro-op of the next pass
  task automatic try_loop(input string req, input int n, input int ldiv,
                          input int ntk, input bit ret, input int base,
                          input int passes, input bit expect_rp);
    int guard;
    for (int p = 0; p < passes; p++) drive_pass(n, ldiv, ntk, ret, base);
    drive_one(n, ldiv, ntk, ret, base, 0);
    if (expect_rp)
      for (int j = 0; j < 2 * n + 1; j++) exp_q.push_back(PW'(base + ((1 + j) % n)));
    @(negedge clk);
    check(replay == expect_rp, req, int'(replay), int'(expect_rp));
    if (expect_rp) begin
      // R9: garbage writes while replaying must not disturb the stream
      in_valid = 1'b1; in_tgt = 1'b1; in_taken = 1'b1; in_ret = 1'b1;
      in_uop = '1; in_line = 8'hEE;
      guard = 0;
      while (exp_q.size() > 0 && guard < 200) begin
        @(negedge clk);
        in_uop = in_uop - 1'b1;
        guard++;
      end
      check(exp_q.size() == 0, "R8 stream drained", exp_q.size(), 0);
      exp_q.delete();
      do_flush();
      check(replay == 1'b0, "R10 replay off after flush", int'(replay), 0);
      check(gate == 1'b0, "R10 gate off after flush", int'(gate), 0);
      check(rp_valid == 1'b0, "R10 valid off after flush", int'(rp_valid), 0);
      // R10: one fresh pass must not restart replay
      drive_pass(n, ldiv, ntk, ret, base);
      drive_one(n, ldiv, ntk, ret, base, 0);
      @(negedge clk);
      check(replay == 1'b0, "R10 body discarded", int'(replay), 0);
    end
    do_flush();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    check(replay == 1'b0, "R1 reset replay", int'(replay), 0);
    check(gate == 1'b0, "R1 reset gate", int'(gate), 0);
    check(rp_valid == 1'b0, "R1 reset valid", int'(rp_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: exactly 64 counted passes, then 65
    try_loop("R7 no replay at threshold", 3, 8, 1, 1'b0, 16'h0100, 64, 1'b0);
    try_loop("R7 R2 replay above threshold", 3, 8, 1, 1'b0, 16'h0200, 65, 1'b1);
    // R3
    try_loop("R3 28 uops qualify", 28, 8, 1, 1'b0, 16'h0300, 65, 1'b1);
    try_loop("R3 29 uops rejected", 29, 8, 1, 1'b0, 16'h0400, 70, 1'b0);
    // R4
    try_loop("R4 4 lines qualify", 8, 2, 1, 1'b0, 16'h0500, 65, 1'b1);
    try_loop("R4 5 lines rejected", 10, 2, 1, 1'b0, 16'h0600, 70, 1'b0);
    // R5
    try_loop("R5 4 taken qualify", 6, 8, 4, 1'b0, 16'h0700, 65, 1'b1);
    try_loop("R5 5 taken rejected", 6, 8, 5, 1'b0, 16'h0800, 70, 1'b0);
    // R6
    try_loop("R6 return rejected", 4, 8, 1, 1'b0 | 1'b1, 16'h0900, 70, 1'b0);
    // R8: single-entry loop
    try_loop("R8 one-entry loop", 1, 8, 1, 1'b0, 16'h0A00, 65, 1'b1);
    // R11: three-entry loop, then a four-entry loop; the longer pass drops it
    for (int p = 0; p < 10; p++) drive_pass(3, 8, 1, 1'b0, 16'h0B00);
    try_loop("R11 length change requalifies", 4, 8, 1, 1'b0, 16'h0C00, 66, 1'b1);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule